// File: doc/BRIEF.md
# Cache Range Maintenance Sequencer

This block walks the tag and state array of a two-way, 128-set cache on behalf of a control request and applies a maintenance operation to every line that overlaps an address range. A request carries a byte start address, a count of 32-bit words and an operation code. The range is widened to whole 64-byte lines: the start is rounded down and the last byte is rounded up. The engine then steps through the lines one by one. For each line it presents the set index to the array, compares the tag of both ways against the line's tag, and acts only on ways that are valid and match.

There are three operations. Writeback copies each matching dirty line to the lower memory and leaves every matching line valid and clean. Invalidate clears valid and dirty on every matching line and moves no data. Writeback-invalidate sends out only the dirty matching lines, then invalidates every matching line, clean or dirty. Line transfers use a valid/ready handshake, and the engine waits as long as the lower side needs. The tag array itself sits outside the block. The engine reads it combinationally through the lookup port and changes it through a per-way write strobe.

The sequencer has five states. IDLE waits for a request. LOOKUP samples the match result for the current line. EMIT offers one line transfer per dirty matching way. UPDATE writes the new state bits. FINISH pulses done. The transitions are:
- IDLE to LOOKUP on a request that has a non-zero count and a non-zero operation.
- IDLE to FINISH on a request that has a zero count or a zero operation.
- LOOKUP to LOOKUP, moving to the next line, when both ways miss and more lines remain.
- LOOKUP to FINISH when both ways miss on the last line.
- LOOKUP to EMIT when a matching way is dirty and the operation includes writeback.
- LOOKUP to UPDATE when there is a hit and no transfer is needed.
- EMIT to EMIT while transfers are still pending.
- EMIT to UPDATE when the last transfer is accepted.
- UPDATE to LOOKUP when more lines remain.
- UPDATE to FINISH on the last line.
- FINISH to IDLE, always.

Top module: `cache_maint_engine`

## Requirements
- R1: After reset, busy, done, wb_valid and st_we are all 0.
- R2: The lines visited run from floor(start/64) to floor((start+4*count-1)/64) inclusive. That end is clamped to the highest line when it passes the top of the address space. A zero count, or operation code 00, visits no line and changes nothing.
- R3: A way hits only when its valid bit is 1 and its stored tag equals address bits 31:13 of the line. The set is address bits 12:6. Lines with no hit get no transfer and no state write.
- R4: Operation code 01 (writeback) sends out every dirty hit way and leaves all hit ways valid=1, dirty=0. Clean hits produce no transfer.
- R5: Operation code 10 (invalidate) sets valid=0 and dirty=0 on every hit way and produces no transfer.
- R6: Operation code 11 (writeback-invalidate) sends out only the dirty hit ways and then sets valid=0 and dirty=0 on every hit way.
- R7: While wb_valid is high and wb_ready is low, wb_valid, wb_addr and wb_way hold steady. No state write occurs while a transfer is offered. Transfers within one line go out lowest way first.
- R8: busy is high from the cycle after an accepted request through the cycle in which done is high. Requests that arrive while busy is high are ignored.
- R9: done is a one-cycle pulse, and busy is low in the next cycle. Counting the accepting edge as one, done appears after 1 + sum of line costs + stall cycles edges. A line costs 1 for a miss and 2 plus its number of transfers for a hit.
- R10: wb_addr is the line's byte address with bits 5:0 zero. wb_way is the index of the way being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, sampled only when idle |
| op | input | 2 | Operation: bit 0 writeback, bit 1 invalidate |
| base_addr | input | 32 | Byte start address of the range |
| word_cnt | input | 16 | Number of 32-bit words in the range |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| ta_set | output | 7 | Set index presented to the tag array |
| ta_tag | input | 2x19 | Stored tag of each way in set ta_set |
| ta_valid | input | 2 | Valid bit of each way in set ta_set |
| ta_dirty | input | 2 | Dirty bit of each way in set ta_set |
| st_we | output | 2 | Per-way state write strobe |
| st_set | output | 7 | Set index for the state write |
| st_valid | output | 1 | New valid value for written ways |
| st_dirty | output | 1 | New dirty value for written ways |
| wb_valid | output | 1 | Line transfer offered |
| wb_ready | input | 1 | Lower memory accepts the transfer |
| wb_addr | output | 32 | Byte address of the line being sent |
| wb_way | output | 1 | Way holding the line being sent |

## Verification
Some rules are checked on every cycle:
- the transfer offer holds steady while it is stalled;
- no state write overlaps a transfer;
- written state is always clean;
- transfer addresses are line aligned;
- an idle request always raises busy;
- done lasts one cycle and busy drops after it.

Other behaviour can only be shown by the bench's scenarios. These include which lines the rounded range covers, the exact set of lines sent and their order, the final valid and dirty bits per operation, clamping at the top of memory, cycle counts under random back-pressure, and rejection of a request made mid-walk. Each scenario is compared against a behavioural model of the array.

// File: rtl/cme_pkg.sv
package cme_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WB    = 2'b01,
        OP_INV   = 2'b10,
        OP_WBINV = 2'b11
    } cme_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOOKUP,
        S_EMIT,
        S_UPDATE,
        S_FINISH
    } cme_state_e;
endpackage

// File: rtl/cme_range.sv
module cme_range #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int OFF_W  = 6,
    localparam int LINE_W = ADDR_W - OFF_W
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CNT_W-1:0]  word_cnt,
    output logic [LINE_W-1:0] first_line,
    output logic [LINE_W-1:0] last_line,
    output logic              empty
);
    logic [ADDR_W:0] span_end;
    logic [LINE_W:0] end_line;

    always_comb begin
        // last byte of the range, one extra bit to catch wrap past the top
        span_end   = {1'b0, base_addr}
                   + {{(ADDR_W-1-CNT_W){1'b0}}, word_cnt, 2'b00}
                   - {{ADDR_W{1'b0}}, 1'b1};
        end_line   = (LINE_W+1)'(span_end >> OFF_W);
        first_line = LINE_W'(base_addr >> OFF_W);
        last_line  = end_line[LINE_W] ? {LINE_W{1'b1}} : end_line[LINE_W-1:0];
        empty      = (word_cnt == '0);
    end
endmodule

// File: rtl/cme_tag_match.sv
module cme_tag_match #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 19
) (
    input  logic [TAG_W-1:0]            line_tag,
    input  logic [WAYS-1:0][TAG_W-1:0]  ta_tag,
    input  logic [WAYS-1:0]             ta_valid,
    input  logic [WAYS-1:0]             ta_dirty,
    output logic [WAYS-1:0]             hit,
    output logic [WAYS-1:0]             dirty_hit
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit[w]       = ta_valid[w] && (ta_tag[w] == line_tag);
        assign dirty_hit[w] = hit[w] && ta_dirty[w];
    end
endmodule

// File: rtl/cache_maint_engine.sv
module cache_maint_engine
    import cme_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SETS       = 128,
    parameter int LINE_BYTES = 64,
    parameter int WAYS       = 2,
    parameter int CNT_W      = 16,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int SET_W  = $clog2(SETS),
    localparam int TAG_W  = ADDR_W - OFF_W - SET_W,
    localparam int LINE_W = ADDR_W - OFF_W,
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [1:0]                 op,
    input  logic [ADDR_W-1:0]          base_addr,
    input  logic [CNT_W-1:0]           word_cnt,
    output logic                       busy,
    output logic                       done,
    output logic [SET_W-1:0]           ta_set,
    input  logic [WAYS-1:0][TAG_W-1:0] ta_tag,
    input  logic [WAYS-1:0]            ta_valid,
    input  logic [WAYS-1:0]            ta_dirty,
    output logic [WAYS-1:0]            st_we,
    output logic [SET_W-1:0]           st_set,
    output logic                       st_valid,
    output logic                       st_dirty,
    output logic                       wb_valid,
    input  logic                       wb_ready,
    output logic [ADDR_W-1:0]          wb_addr,
    output logic [WAY_W-1:0]           wb_way
);
    cme_state_e        state, state_nx;
    logic [LINE_W-1:0] cur_line, last_q;
    logic [1:0]        op_q;
    logic [WAYS-1:0]   hit_q, pend_q, sel_oh;
    logic [WAY_W-1:0]  sel_idx;

    logic [LINE_W-1:0] first_line, last_line;
    logic              range_empty;
    logic [WAYS-1:0]   hit, dirty_hit, want_wb;
    logic              at_last;

    cme_range #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .OFF_W(OFF_W)) u_range (
        .base_addr (base_addr),
        .word_cnt  (word_cnt),
        .first_line(first_line),
        .last_line (last_line),
        .empty     (range_empty)
    );

    cme_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .line_tag (cur_line[LINE_W-1:SET_W]),
        .ta_tag   (ta_tag),
        .ta_valid (ta_valid),
        .ta_dirty (ta_dirty),
        .hit      (hit),
        .dirty_hit(dirty_hit)
    );

    assign want_wb = dirty_hit & {WAYS{op_q[0]}};
    assign at_last = (cur_line == last_q);
    assign sel_oh  = pend_q & (~pend_q + {{(WAYS-1){1'b0}}, 1'b1});

    always_comb begin
        sel_idx = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (pend_q[i]) sel_idx = WAY_W'(i);
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:
                if (start) begin
                    state_nx = (range_empty || op == OP_NONE) ? S_FINISH : S_LOOKUP;
                end
            S_LOOKUP:
                if (hit == '0)          state_nx = at_last ? S_FINISH : S_LOOKUP;
                else if (want_wb != '0) state_nx = S_EMIT;
                else                    state_nx = S_UPDATE;
            S_EMIT:
                if (wb_ready && (pend_q & ~sel_oh) == '0) state_nx = S_UPDATE;
            S_UPDATE:
                state_nx = at_last ? S_FINISH : S_LOOKUP;
            S_FINISH:
                state_nx = S_IDLE;
            default:
                state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // walk registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_line <= '0;
            last_q   <= '0;
            op_q     <= '0;
            hit_q    <= '0;
            pend_q   <= '0;
        end else begin
            unique case (state)
                S_IDLE:
                    if (start) begin
                        cur_line <= first_line;
                        last_q   <= last_line;
                        op_q     <= op;
                    end
                S_LOOKUP: begin
                    hit_q  <= hit;
                    pend_q <= want_wb;
                    if (hit == '0) cur_line <= cur_line + 1'b1;
                end
                S_EMIT:
                    if (wb_ready) pend_q <= pend_q & ~sel_oh;
                S_UPDATE:
                    cur_line <= cur_line + 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy     = (state != S_IDLE);
        done     = (state == S_FINISH);
        ta_set   = cur_line[SET_W-1:0];
        st_set   = cur_line[SET_W-1:0];
        st_we    = (state == S_UPDATE) ? hit_q : '0;
        st_valid = ~op_q[1];
        st_dirty = 1'b0;
        wb_valid = (state == S_EMIT);
        wb_addr  = {cur_line, {OFF_W{1'b0}}};
        wb_way   = sel_idx;
    end
endmodule

// File: rtl/cme_checker.sv
module cme_checker #(
    parameter int ADDR_W = 32,
    parameter int WAYS   = 2,
    parameter int OFF_W  = 6,
    parameter int WAY_W  = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              wb_valid,
    input logic              wb_ready,
    input logic [ADDR_W-1:0] wb_addr,
    input logic [WAY_W-1:0]  wb_way,
    input logic [WAYS-1:0]   st_we,
    input logic              st_dirty
);
    // R7
    wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr) && $stable(wb_way));

    // R7
    no_write_during_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> st_we == '0);

    // R4
    clean_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_we != '0 |-> !st_dirty);

    // R10
    wb_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> wb_addr[OFF_W-1:0] == '0);

    // R8
    busy_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start |=> busy);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    // R9
    done_implies_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
endmodule

bind cache_maint_engine cme_checker #(
    .ADDR_W(ADDR_W), .WAYS(WAYS), .OFF_W(OFF_W), .WAY_W(WAY_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr),
    .wb_way(wb_way), .st_we(st_we), .st_dirty(st_dirty)
);

// File: tb/sim_cache_maint_engine.sv
module sim_cache_maint_engine;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n, start, busy, done;
    logic [1:0]        op_sel;
    logic [31:0]       base_addr;
    logic [15:0]       word_cnt;
    logic [6:0]        ta_set, st_set;
    logic [1:0][18:0]  ta_tag;
    logic [1:0]        ta_valid, ta_dirty, st_we;
    logic              st_valid, st_dirty, wb_valid, wb_ready;
    logic [31:0]       wb_addr;
    logic [0:0]        wb_way;

    cache_maint_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op_sel),
        .base_addr(base_addr), .word_cnt(word_cnt), .busy(busy), .done(done),
        .ta_set(ta_set), .ta_tag(ta_tag), .ta_valid(ta_valid), .ta_dirty(ta_dirty),
        .st_we(st_we), .st_set(st_set), .st_valid(st_valid), .st_dirty(st_dirty),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_way(wb_way)
    );

    // behavioural tag/state array
    logic [18:0] tag_m [0:127][0:1];
    bit          v_m   [0:127][0:1];
    bit          d_m   [0:127][0:1];
    bit          e_v   [0:127][0:1];
    bit          e_d   [0:127][0:1];
    logic [31:0] eq_addr[$];
    int          eq_way[$];

    assign ta_tag[0] = tag_m[ta_set][0];
    assign ta_tag[1] = tag_m[ta_set][1];
    assign ta_valid  = {v_m[ta_set][1], v_m[ta_set][0]};
    assign ta_dirty  = {d_m[ta_set][1], d_m[ta_set][0]};

    always @(posedge clk) begin
        for (int w = 0; w < 2; w++) begin
            if (st_we[w]) begin
                v_m[st_set][w] <= st_valid;
                d_m[st_set][w] <= st_dirty;
            end
        end
    end

    int n_tests = 0, n_fail = 0, cycles = 0;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL R9 watchdog expired: actual %0d expected <150000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic fill(int k);
        for (int s = 0; s < 128; s++) begin
            for (int w = 0; w < 2; w++) begin
                tag_m[s][w] = 19'h10 + 19'(w);
                v_m[s][w]   = ((s + w + k) % 3) != 0;
                d_m[s][w]   = ((s * 3 + w + k) % 4) < 2;
            end
        end
    endtask

    task automatic build_expect(logic [31:0] base, int cnt, logic [1:0] op, output int cost);
        longint first_l, last_l, endb;
        cost = 0;
        eq_addr.delete();
        eq_way.delete();
        for (int s = 0; s < 128; s++) begin
            for (int w = 0; w < 2; w++) begin
                e_v[s][w] = v_m[s][w];
                e_d[s][w] = d_m[s][w];
            end
        end
        if (cnt == 0 || op == 2'b00) return;
        first_l = longint'(base) >> 6;
        endb    = longint'(base) + longint'(cnt) * 4 - 1;
        last_l  = endb >> 6;
        if (last_l > 64'h3FFFFFF) last_l = 64'h3FFFFFF;
        for (longint L = first_l; L <= last_l; L++) begin
            int  s;
            bit  any;
            s   = int'(L % 128);
            any = 0;
            for (int w = 0; w < 2; w++) begin
                if (v_m[s][w] && tag_m[s][w] == 19'(L >> 7)) begin
                    any = 1;
                    if (op[0] && d_m[s][w]) begin
                        eq_addr.push_back(32'(L << 6));
                        eq_way.push_back(w);
                        cost++;
                    end
                    e_v[s][w] = !op[1];
                    e_d[s][w] = 0;
                end
            end
            cost += any ? 2 : 1;
        end
    endtask

    task automatic run_op(string req, logic [31:0] base, int cnt, logic [1:0] op,
                          bit rnd, int inj);
        int  cost, edges, stalls, mism;
        bit  seen;
        build_expect(base, cnt, op, cost);
        @(negedge clk);
        base_addr = base;
        word_cnt  = cnt[15:0];
        op_sel    = op;
        start     = 1'b1;
        edges = 0; stalls = 0; seen = 0;
        while (!seen) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            start    = 1'b0;
            wb_ready = rnd ? 1'($urandom % 2) : 1'b1;
            if (done) seen = 1;
            else begin
                check(busy, "R8", "busy during walk", busy, 1);
                if (wb_valid && wb_ready) begin
                    if (eq_addr.size() == 0)
                        check(0, req, "unexpected writeback", wb_addr, 0);
                    else begin
                        check(wb_addr == eq_addr[0], "R10", "writeback address", wb_addr, eq_addr[0]);
                        check(int'(wb_way) == eq_way[0], "R7", "writeback way order", wb_way, eq_way[0]);
                        void'(eq_addr.pop_front());
                        void'(eq_way.pop_front());
                    end
                end
                if (wb_valid && !wb_ready) stalls++;
                if (edges == inj) begin
                    start     = 1'b1;
                    base_addr = 32'h0002_0000;
                    word_cnt  = 16'd4096;
                    op_sel    = 2'b10;
                end
            end
        end
        wb_ready = 1'b1;
        check(edges == 1 + cost + stalls, "R9", "edges until done", edges, 1 + cost + stalls);
        check(eq_addr.size() == 0, req, "writebacks still missing", eq_addr.size(), 0);
        @(posedge clk);
        @(negedge clk);
        check(!busy && !done, "R9", "busy/done after pulse", {busy, done}, 0);
        mism = 0;
        for (int s = 0; s < 128; s++) begin
            for (int w = 0; w < 2; w++) begin
                if (v_m[s][w] != e_v[s][w] || d_m[s][w] != e_d[s][w]) mism++;
            end
        end
        check(mism == 0, req, "state array mismatches", mism, 0);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; wb_ready = 1'b1;
        op_sel = 2'b00; base_addr = '0; word_cnt = '0;
        fill(0);
        repeat (3) @(negedge clk);
        check(!busy && !done && !wb_valid && st_we == 2'b00, "R1", "outputs in reset",
              {busy, done, wb_valid, st_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !wb_valid && st_we == 2'b00, "R1", "outputs after reset",
              {busy, done, wb_valid, st_we}, 0);

        fill(0); run_op("R4", 32'h0002_0000, 256, 2'b01, 0, -1);
        fill(1); run_op("R6", 32'h0002_0010, 40, 2'b11, 1, -1);
        fill(2); run_op("R5", 32'h0002_1FF0, 300, 2'b10, 0, -1);
        fill(3); run_op("R2", 32'h0002_0000, 0, 2'b01, 0, -1);
        fill(0); run_op("R2", 32'h0002_0000, 100, 2'b00, 0, -1);
        fill(1); run_op("R3", 32'h8000_0000, 64, 2'b11, 0, -1);
        fill(2); run_op("R8", 32'h0002_0400, 512, 2'b01, 1, 3);
        fill(3); run_op("R2", 32'h0002_003C, 2, 2'b11, 0, -1);
        fill(0); run_op("R2", 32'hFFFF_FFC0, 32, 2'b11, 0, -1);
        fill(1); run_op("R6", 32'h0002_1000, 2048, 2'b11, 1, -1);
        fill(2); run_op("R7", 32'h0002_0000, 1024, 2'b01, 1, -1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule